// File: doc/BRIEF.md
# Load/Store Port Protocol Monitor

This block sits beside one load/store port and watches the handshake between the unit that issues a memory access and the buffer that serves it. It drives none of the port's signals. It follows each transaction through three phases: idle, load in progress and store in progress. Whenever the requester or the memory side breaks a rule of the port, it sets a sticky violation flag.

Each rule has its own flag bit. A single clear input empties the whole flag vector. Two saturating counters record completed loads and completed stores separately. An abort input puts the phase tracking back to idle and raises no flags. A typical use is to tie the monitor to a port in simulation or in an emulation build and read the flag vector after a run.

A transaction starts in an idle cycle in which a request line is high. If both request lines are high, the load wins. The transaction ends on its completion cycle, which is a cycle with an address exception, load data valid or store data valid. The monitor is back in idle on the next cycle.

Top module: `ldst_port_monitor`

## Requirements
- R1: After reset, the flag vector `violFlags` is 0 and both counters are 0.
- R2: Bit 0 of `violFlags` is set when `ldReq` and `stReq` are high in the same cycle.
- R3: Bit 1 is set when busy is low in a cycle where a transaction is active (from the cycle after the request onward) and that cycle is not its completion cycle.
- R4: Bit 2 is set when, in an active cycle with busy high after address-valid was first seen in the transaction, `addr` differs from the value captured at that first cycle or address-valid is low.
- R5: Bit 3 is set when `addrAck` is high on two consecutive cycles, or when `addrExc` is high on two consecutive cycles.
- R6: Bit 4 is set when `addrAck` and `addrExc` are high in the same cycle.
- R7: Bit 5 is set when load-data-valid rises (it is high now and was low on the previous cycle) while busy is still high.
- R8: Bit 6 is set when load-data-valid is high outside a load, or inside a load before an address acknowledge was seen in an earlier cycle of that load.
- R9: Bit 7 is set when store-data-valid is high outside a store.
- R10: Flags stay set until `clearFlags` is high. `clearFlags` zeroes every flag on the next cycle and overrides any violation in the same cycle.
- R11: `abortIn` returns the tracking to idle on the next cycle. No flag is raised and no counter moves in the abort cycle.
- R12: `ldCount` increments on each load-data-valid cycle in a load, and `stCount` increments on each store-data-valid cycle in a store. Each saturates at its all-ones value.
- R13: A completion cycle returns the tracking to idle. An address-exception completion changes neither counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clearFlags | input | 1 | Clear all violation flags |
| abortIn | input | 1 | Abort the tracked transaction and return to idle |
| ldReq | input | 1 | Load request from the requester |
| stReq | input | 1 | Store request from the requester |
| busy | input | 1 | Port busy indication |
| addrValid | input | 1 | Address valid from the requester |
| addr | input | AddrWidth | Access address |
| addrAck | input | 1 | Address acknowledge from the memory side |
| addrExc | input | 1 | Address exception from the memory side |
| ldValid | input | 1 | Load data valid from the memory side |
| stValid | input | 1 | Store data valid from the requester |
| violFlags | output | 8 | Sticky violation flags, bit positions as in R2 to R9 |
| ldCount | output | CountWidth | Completed loads, saturating |
| stCount | output | CountWidth | Completed stores, saturating |

## Verification
The bench walks clean loads and stores with three-stage timing. A monitor that treats busy as required in the completion cycle would flag them. A monitor that wrongly checks the address after busy drops would also flag them.

Each rule is then broken on its own, so a flag wired to the wrong bit or a rule that misses its window shows up as a wrong vector. Corner cases include:
- a held address that drops its valid line;
- load data returned in the very cycle of the acknowledge;
- a clear that coincides with a fresh violation;
- an abort that coincides with an orphan store.

A counter that wraps instead of saturating is caught by driving more loads than a narrowed counter can hold.

// File: rtl/ldst_mon_pkg.sv
package ldst_mon_pkg;

  localparam int NumFlags = 8;

  localparam int FlagReqBoth   = 0;
  localparam int FlagBusyEarly = 1;
  localparam int FlagAddrMove  = 2;
  localparam int FlagRespHeld  = 3;
  localparam int FlagRespBoth  = 4;
  localparam int FlagLdBusy    = 5;
  localparam int FlagLdEarly   = 6;
  localparam int FlagStOrphan  = 7;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOAD  = 2'd1,
    PH_STORE = 2'd2
  } phase_e;

  typedef struct packed {
    logic                captureAddr;
    logic                addrGuard;
    logic                bumpLd;
    logic                bumpSt;
    logic [NumFlags-1:0] flagSet;
  } strobe_t;

endpackage

// File: rtl/ldst_mon_ctrl.sv
module ldst_mon_ctrl
  import ldst_mon_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    abortIn,
  input  logic    ldReq,
  input  logic    stReq,
  input  logic    busy,
  input  logic    addrValid,
  input  logic    addrAck,
  input  logic    addrExc,
  input  logic    ldValid,
  input  logic    stValid,
  output strobe_t strobes
);

  phase_e phaseQ;
  logic   ackSeenQ;
  logic   addrSeenQ;
  logic   prevAckQ;
  logic   prevExcQ;
  logic   prevLdQ;

  logic active;
  logic compl;
  logic inLoad;
  logic inStore;
  logic [NumFlags-1:0] rawFlags;

  assign active  = (phaseQ != PH_IDLE);
  assign inLoad  = (phaseQ == PH_LOAD);
  assign inStore = (phaseQ == PH_STORE);
  assign compl   = addrExc | ldValid | stValid;

  always_comb begin
    rawFlags                = '0;
    rawFlags[FlagReqBoth]   = ldReq & stReq;
    rawFlags[FlagBusyEarly] = active & ~busy & ~compl;
    rawFlags[FlagAddrMove]  = active & addrSeenQ & busy & ~addrValid;
    rawFlags[FlagRespHeld]  = (addrAck & prevAckQ) | (addrExc & prevExcQ);
    rawFlags[FlagRespBoth]  = addrAck & addrExc;
    rawFlags[FlagLdBusy]    = ldValid & ~prevLdQ & busy;
    rawFlags[FlagLdEarly]   = ldValid & ~(inLoad & ackSeenQ);
    rawFlags[FlagStOrphan]  = stValid & ~inStore;
  end

  always_comb begin
    strobes.flagSet     = abortIn ? '0 : rawFlags;
    strobes.captureAddr = active & ~addrSeenQ & addrValid & ~abortIn;
    strobes.addrGuard   = active & addrSeenQ & busy & ~abortIn;
    strobes.bumpLd      = inLoad & ldValid & ~abortIn;
    strobes.bumpSt      = inStore & stValid & ~abortIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ    <= PH_IDLE;
      ackSeenQ  <= 1'b0;
      addrSeenQ <= 1'b0;
      prevAckQ  <= 1'b0;
      prevExcQ  <= 1'b0;
      prevLdQ   <= 1'b0;
    end else begin
      prevAckQ <= addrAck;
      prevExcQ <= addrExc;
      prevLdQ  <= ldValid;
      if (abortIn) begin
        phaseQ    <= PH_IDLE;
        ackSeenQ  <= 1'b0;
        addrSeenQ <= 1'b0;
      end else if (!active) begin
        ackSeenQ  <= 1'b0;
        addrSeenQ <= 1'b0;
        if (ldReq)      phaseQ <= PH_LOAD;
        else if (stReq) phaseQ <= PH_STORE;
      end else if (compl) begin
        phaseQ    <= PH_IDLE;
        ackSeenQ  <= 1'b0;
        addrSeenQ <= 1'b0;
      end else begin
        if (addrAck)             ackSeenQ  <= 1'b1;
        if (strobes.captureAddr) addrSeenQ <= 1'b1;
      end
    end
  end

  // R11: abort always lands in idle
  p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    abortIn |=> (phaseQ == PH_IDLE));

  // R13: a completion ends the transaction
  p_done_idle_r13: assert property (@(posedge clk) disable iff (!rstN)
    (active && compl && !abortIn) |=> (phaseQ == PH_IDLE));

  // R12: a count strobe only arrives from an active phase
  p_bump_active_r12: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.bumpLd || strobes.bumpSt) |-> (phaseQ != PH_IDLE));

endmodule

// File: rtl/ldst_mon_dp.sv
module ldst_mon_dp
  import ldst_mon_pkg::*;
#(
  parameter int AddrWidth  = 48,
  parameter int CountWidth = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clearFlags,
  input  logic [AddrWidth-1:0]  addr,
  input  strobe_t               strobes,
  output logic [NumFlags-1:0]   flagsOut,
  output logic [CountWidth-1:0] ldCountOut,
  output logic [CountWidth-1:0] stCountOut
);

  localparam logic [CountWidth-1:0] CountMax = {CountWidth{1'b1}};
  localparam int NumCounters = 2;

  logic [AddrWidth-1:0]  heldAddrQ;
  logic [NumFlags-1:0]   flagQ;
  logic [NumFlags-1:0]   flagNext;
  logic                  addrMismatch;
  logic [CountWidth-1:0] cntQ [NumCounters];

  assign addrMismatch = strobes.addrGuard & (addr != heldAddrQ);

  always_comb begin
    flagNext               = strobes.flagSet;
    flagNext[FlagAddrMove] = strobes.flagSet[FlagAddrMove] | addrMismatch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldAddrQ <= '0;
    end else if (strobes.captureAddr) begin
      heldAddrQ <= addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           flagQ <= '0;
    else if (clearFlags) flagQ <= '0;
    else                 flagQ <= flagQ | flagNext;
  end

  for (genvar k = 0; k < NumCounters; k++) begin : g_cnt
    logic bump;
    assign bump = (k == 0) ? strobes.bumpLd : strobes.bumpSt;
    always_ff @(posedge clk) begin
      if (!rstN)                          cntQ[k] <= '0;
      else if (bump && cntQ[k] != CountMax) cntQ[k] <= cntQ[k] + 1'b1;
    end
  end

  assign flagsOut   = flagQ;
  assign ldCountOut = cntQ[0];
  assign stCountOut = cntQ[1];

  // R10: flags never drop without a clear
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    !clearFlags |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  // R10: clear empties the vector
  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    clearFlags |=> (flagQ == '0));

  // R12: counters move by at most one and never go back
  p_ld_step_r12: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cntQ[0] >= $past(cntQ[0])) && (cntQ[0] - $past(cntQ[0]) <= 1));
  p_st_step_r12: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cntQ[1] >= $past(cntQ[1])) && (cntQ[1] - $past(cntQ[1]) <= 1));

endmodule

// File: rtl/ldst_port_monitor.sv
module ldst_port_monitor
  import ldst_mon_pkg::*;
#(
  parameter int AddrWidth  = 48,
  parameter int CountWidth = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clearFlags,
  input  logic                  abortIn,
  input  logic                  ldReq,
  input  logic                  stReq,
  input  logic                  busy,
  input  logic                  addrValid,
  input  logic [AddrWidth-1:0]  addr,
  input  logic                  addrAck,
  input  logic                  addrExc,
  input  logic                  ldValid,
  input  logic                  stValid,
  output logic [7:0]            violFlags,
  output logic [CountWidth-1:0] ldCount,
  output logic [CountWidth-1:0] stCount
);

  strobe_t strobes;

  ldst_mon_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .abortIn   (abortIn),
    .ldReq     (ldReq),
    .stReq     (stReq),
    .busy      (busy),
    .addrValid (addrValid),
    .addrAck   (addrAck),
    .addrExc   (addrExc),
    .ldValid   (ldValid),
    .stValid   (stValid),
    .strobes   (strobes)
  );

  ldst_mon_dp #(
    .AddrWidth  (AddrWidth),
    .CountWidth (CountWidth)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .clearFlags (clearFlags),
    .addr       (addr),
    .strobes    (strobes),
    .flagsOut   (violFlags),
    .ldCountOut (ldCount),
    .stCountOut (stCount)
  );

  // R2: simultaneous requests are caught
  p_req_both_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ldReq && stReq && !abortIn && !clearFlags) |=> violFlags[FlagReqBoth]);

  // R6: simultaneous acknowledge and exception are caught
  p_resp_both_r6: assert property (@(posedge clk) disable iff (!rstN)
    (addrAck && addrExc && !abortIn && !clearFlags) |=> violFlags[FlagRespBoth]);

endmodule

// File: tb/ldst_port_monitor_test.sv
module ldst_port_monitor_test;

  localparam int AW = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearFlags = 0, abortIn = 0, ldReq = 0, stReq = 0, busy = 0;
  logic addrValid = 0, addrAck = 0, addrExc = 0, ldValid = 0, stValid = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    violFlags;
  logic [CW-1:0] ldCount, stCount;

  int checks = 0;
  int fails = 0;
  int expLd = 0;
  int expSt = 0;

  always #2 clk = ~clk;

  ldst_port_monitor #(.AddrWidth(AW), .CountWidth(CW)) uut (
    .clk(clk), .rstN(rstN), .clearFlags(clearFlags), .abortIn(abortIn),
    .ldReq(ldReq), .stReq(stReq), .busy(busy), .addrValid(addrValid),
    .addr(addr), .addrAck(addrAck), .addrExc(addrExc), .ldValid(ldValid),
    .stValid(stValid), .violFlags(violFlags), .ldCount(ldCount), .stCount(stCount)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idleIn();
    clearFlags = 0; abortIn = 0; ldReq = 0; stReq = 0; busy = 0;
    addrValid = 0; addrAck = 0; addrExc = 0; ldValid = 0; stValid = 0;
  endtask

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic checkAll(string req, int expFlags);
    check(req, int'(violFlags), expFlags);
    check(req, int'(ldCount), expLd > 15 ? 15 : expLd);
    check(req, int'(stCount), expSt);
  endtask

  task automatic clearAll();
    idleIn(); clearFlags = 1; tick();
    idleIn(); tick();
    check("R10", int'(violFlags), 0);
  endtask

  task automatic startReq(bit isLoad);
    idleIn(); ldReq = isLoad; stReq = !isLoad; busy = 1; tick();
  endtask

  task automatic giveAddr(logic [AW-1:0] a);
    idleIn(); busy = 1; addrValid = 1; addr = a; tick();
  endtask

  task automatic ackAddr();
    idleIn(); busy = 1; addrValid = 1; addrAck = 1; tick();
  endtask

  task automatic doAbort();
    idleIn(); abortIn = 1; tick();
    idleIn(); tick();
  endtask

  task automatic tLoadOk();
    startReq(1); giveAddr(16'h0040); ackAddr();
    idleIn(); ldValid = 1; tick();
    expLd++;
    idleIn(); tick();
    checkAll("R12 clean load", 0);
  endtask

  task automatic tStoreOk();
    startReq(0); giveAddr(16'h0080); ackAddr();
    idleIn(); busy = 1; addrValid = 1; stValid = 1; tick();
    expSt++;
    idleIn(); tick();
    checkAll("R12 clean store", 0);
  endtask

  task automatic tReqBoth();
    idleIn(); ldReq = 1; stReq = 1; busy = 1; tick();
    doAbort();
    checkAll("R2", 8'h01);
    clearAll();
  endtask

  task automatic tBusyEarly();
    startReq(1);
    idleIn(); tick();
    doAbort();
    checkAll("R3", 8'h02);
    clearAll();
  endtask

  task automatic tAddrMove(bit dropValid);
    startReq(1); giveAddr(16'h1234);
    if (dropValid) begin idleIn(); busy = 1; tick(); end
    else giveAddr(16'h1235);
    doAbort();
    checkAll(dropValid ? "R4 valid drop" : "R4 value change", 8'h04);
    clearAll();
  endtask

  task automatic tRespHeld();
    startReq(1); giveAddr(16'h0010); ackAddr(); ackAddr();
    idleIn(); ldValid = 1; tick();
    expLd++;
    idleIn(); tick();
    checkAll("R5", 8'h08);
    clearAll();
  endtask

  task automatic tRespBoth();
    startReq(1); giveAddr(16'h0020);
    idleIn(); addrValid = 1; addrAck = 1; addrExc = 1; tick();
    idleIn(); tick();
    checkAll("R6", 8'h10);
    clearAll();
  endtask

  task automatic tExcDone();
    startReq(0); giveAddr(16'h0030);
    idleIn(); addrExc = 1; tick();
    idleIn(); tick();
    idleIn(); tick();
    checkAll("R13 exception completion", 0);
  endtask

  task automatic tLdBusy();
    startReq(1); giveAddr(16'h0050); ackAddr();
    idleIn(); busy = 1; addrValid = 1; ldValid = 1; tick();
    expLd++;
    idleIn(); tick();
    checkAll("R7", 8'h20);
    clearAll();
  endtask

  task automatic tLdEarly();
    startReq(1); giveAddr(16'h0060);
    idleIn(); addrAck = 1; ldValid = 1; tick();
    expLd++;
    idleIn(); tick();
    checkAll("R8", 8'h40);
    clearAll();
  endtask

  task automatic tStOrphan();
    idleIn(); stValid = 1; tick();
    idleIn(); tick(); tick();
    checkAll("R9 sticky orphan store", 8'h80);
    idleIn(); clearFlags = 1; stValid = 1; tick();
    idleIn(); tick();
    check("R10 clear wins", int'(violFlags), 0);
  endtask

  task automatic tAbort();
    startReq(1);
    idleIn(); abortIn = 1; stValid = 1; tick();
    idleIn(); tick();
    checkAll("R11", 0);
  endtask

  task automatic tSaturate();
    for (int i = 0; i < 20; i++) begin
      idleIn(); ldReq = 1; busy = 1; tick();
      idleIn(); busy = 1; addrValid = 1; addrAck = 1; addr = 16'h0100; tick();
      idleIn(); ldValid = 1; tick();
      expLd++;
    end
    idleIn(); tick();
    check("R12 saturation", int'(ldCount), 15);
    check("R12 store count untouched", int'(stCount), expSt);
    check("R12 no flags", int'(violFlags), 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    idleIn();
    rstN = 0;
    repeat (3) tick();
    rstN = 1;
    tick();
    checkAll("R1", 0);
    tLoadOk();
    tStoreOk();
    tReqBoth();
    tBusyEarly();
    tAddrMove(0);
    tAddrMove(1);
    tRespHeld();
    tRespBoth();
    tExcDone();
    tLdBusy();
    tLdEarly();
    tStOrphan();
    tAbort();
    tSaturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule